// File: doc/BRIEF.md
# Fall-Through Ripple FIFO

A synchronous first-in-first-out buffer built as a chain of sixteen stages. Each stage holds a 4-bit word and a single occupancy marker. There are no read or write pointers and no fill counter. On every clock, each filled stage hands its word to the next stage when that stage is empty. Words therefore fall through toward the output end, one stage per clock, and vacancies climb back toward the input end at the same rate.

A producer presents a word and raises the shift-in strobe. The word is captured on the rising edge of the strobe, and only while the input-ready flag is high. A consumer reads the word shown at the output and lowers the shift-out strobe to discard it. The discard happens on the falling edge of the strobe, and only while the output-ready flag is high and the output-disable control is low. A synchronous master reset empties the chain by clearing every marker. It does not touch the stored words.

Top module: `ripple_fifo`

## Requirements
- R1: After the asynchronous reset, and on the clock after any cycle with master reset high, the in-ready flag is 1 and the out-ready flag is 0.
- R2: A word is captured only on a 0-to-1 transition of shift-in that is seen at a clock while in-ready is 1. Holding shift-in high captures exactly one word.
- R3: On the clock after a capture, in-ready is 0. If the second stage is empty, in-ready returns to 1 one clock later.
- R4: A word captured into an empty FIFO sets out-ready exactly 15 clocks after the capturing clock, and the data output then shows that word.
- R5: Words leave in the order in which they were captured, and the data output holds its value while out-ready is 1 and no unload occurs.
- R6: A 1-to-0 transition of shift-out, while out-ready is 1 and output-disable is 0, removes the output word. Out-ready is 0 on the next clock. It is 1 again one clock later when the stage before the output was full.
- R7: Shift-out falling edges have no effect while the FIFO is empty or while output-disable is 1.
- R8: A 1-to-0 transition of output-disable, seen while shift-out is 0 and out-ready is 1, removes the output word just as a shift-out falling edge would.
- R9: Master reset leaves the stored words unchanged, so the data output keeps its value across it. A word loaded afterwards replaces that value when it arrives.
- R10: The output-enable signal is 1 exactly when output-disable is 0.
- R11: The FIFO holds exactly 16 words. While it is full, in-ready stays 0 and further shift-in edges are ignored.
- R12: Strobe edges seen during a clock with master reset high neither load nor unload a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mreset_i | input | 1 | Synchronous master reset; clears all markers |
| shift_in_i | input | 1 | Load strobe; acts on its rising edge |
| data_i | input | 4 | Word to load |
| shift_out_i | input | 1 | Unload strobe; acts on its falling edge |
| out_dis_i | input | 1 | Output disable, active high |
| in_ready_o | output | 1 | First stage is empty |
| out_ready_o | output | 1 | Last stage holds a valid word |
| data_o | output | 4 | Word in the last stage |
| data_oe_o | output | 1 | Drive enable for data_o |

## Verification
The checker watches several rules on every clock:
- the flag state that follows a master reset;
- in-ready dropping after a capture;
- out-ready dropping after either kind of unload;
- the output word staying put, with out-ready held, while output-disable is high.

Some behaviours only the bench scenarios can show: the 15-clock fall-through latency, first-in-first-out order over a full sixteen-word fill and drain, the exact capacity limit, single capture under a held strobe, and data surviving master reset.

// File: rtl/ripple_fifo_pkg.sv
package ripple_fifo_pkg;
  parameter int unsigned RF_DEPTH = 16;
  parameter int unsigned RF_WIDTH = 4;

  // index of each strobe in the history register
  typedef enum int unsigned {
    STB_SHIFT_IN  = 0,
    STB_SHIFT_OUT = 1,
    STB_OUT_DIS   = 2
  } strobe_e;

  localparam int unsigned RF_NUM_STROBES = 3;
endpackage

// File: rtl/rf_strobe_hist.sv
module rf_strobe_hist #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] strobe_i,
  output logic [N-1:0] prev_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_o <= '0;
    else         prev_o <= strobe_i;
  end
endmodule

// File: rtl/rf_stage.sv
module rf_stage #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             take_i,
  input  logic             give_i,
  input  logic [WIDTH-1:0] d_i,
  output logic             mark_o,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mark_o <= 1'b0;
    else if (clr_i)  mark_o <= 1'b0;
    else if (take_i) mark_o <= 1'b1;
    else if (give_i) mark_o <= 1'b0;
  end

  // master reset invalidates but never rewrites the word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q_o <= '0;
    else if (take_i && !clr_i)  q_o <= d_i;
  end
endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo
  import ripple_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = RF_DEPTH,
  parameter int unsigned WIDTH = RF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mreset_i,
  input  logic             shift_in_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             shift_out_i,
  input  logic             out_dis_i,
  output logic             in_ready_o,
  output logic             out_ready_o,
  output logic [WIDTH-1:0] data_o,
  output logic             data_oe_o
);
  localparam int unsigned LAST = DEPTH - 1;
  localparam int unsigned NSTB = RF_NUM_STROBES;

  logic [NSTB-1:0] stb_now, stb_prev;
  logic            in_rise, out_fall, dis_fall;
  logic            load, unload;

  logic [DEPTH-1:0]            mark;
  logic [DEPTH-1:0]            take;
  logic [DEPTH-1:0]            give;
  logic [DEPTH-1:0][WIDTH-1:0] word;

  always_comb begin
    stb_now                = '0;
    stb_now[STB_SHIFT_IN]  = shift_in_i;
    stb_now[STB_SHIFT_OUT] = shift_out_i;
    stb_now[STB_OUT_DIS]   = out_dis_i;
  end

  rf_strobe_hist #(.N(NSTB)) u_hist (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (stb_now),
    .prev_o   (stb_prev)
  );

  assign in_rise  = shift_in_i  & ~stb_prev[STB_SHIFT_IN];
  assign out_fall = ~shift_out_i & stb_prev[STB_SHIFT_OUT];
  assign dis_fall = ~out_dis_i  & stb_prev[STB_OUT_DIS];

  assign load   = ~mreset_i & in_rise & ~mark[0];
  // re-enabling the output with shift-out already low counts as an unload
  assign unload = ~mreset_i & mark[LAST] &
                  ((out_fall & ~out_dis_i) | (dis_fall & ~shift_out_i));

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign take[i] = load;
    end else begin : g_body
      assign take[i] = mark[i-1] & ~mark[i];
    end

    if (i == LAST) begin : g_tail
      assign give[i] = unload;
    end else begin : g_pass
      assign give[i] = mark[i] & ~mark[i+1];
    end

    rf_stage #(.WIDTH(WIDTH)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (mreset_i),
      .take_i (take[i]),
      .give_i (give[i]),
      .d_i    ((i == 0) ? data_i : word[(i == 0) ? 0 : i-1]),
      .mark_o (mark[i]),
      .q_o    (word[i])
    );
  end

  assign in_ready_o  = ~mark[0];
  assign out_ready_o = mark[LAST];
  assign data_o      = word[LAST];
  assign data_oe_o   = ~out_dis_i;
endmodule

// File: rtl/ripple_fifo_chk.sv
module ripple_fifo_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mreset_i,
  input logic             shift_in_i,
  input logic             shift_out_i,
  input logic             out_dis_i,
  input logic             in_ready_o,
  input logic             out_ready_o,
  input logic [WIDTH-1:0] data_o
);
  AST_MRESET_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreset_i |=> (in_ready_o && !out_ready_o)); // R1

  AST_LOAD_BLOCKS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreset_i && $rose(shift_in_i) && in_ready_o) |=> !in_ready_o); // R3

  AST_UNLOAD_CLEARS_OUTPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreset_i && $fell(shift_out_i) && !out_dis_i && out_ready_o) |=> !out_ready_o); // R6

  AST_DISABLED_HOLDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreset_i && out_dis_i && out_ready_o) |=> out_ready_o); // R7

  AST_DISABLED_HOLDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreset_i && out_dis_i && out_ready_o) |=> $stable(data_o)); // R5

  AST_ENABLE_DISCARDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreset_i && $fell(out_dis_i) && !shift_out_i && out_ready_o) |=> !out_ready_o); // R8
endmodule

bind ripple_fifo ripple_fifo_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mreset_i    (mreset_i),
  .shift_in_i  (shift_in_i),
  .shift_out_i (shift_out_i),
  .out_dis_i   (out_dis_i),
  .in_ready_o  (in_ready_o),
  .out_ready_o (out_ready_o),
  .data_o      (data_o)
);

// File: tb/ripple_fifo_tb.sv
module ripple_fifo_tb;
  localparam int unsigned W = 4;
  localparam int unsigned D = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mreset = 1'b0;
  logic         shin = 1'b0;
  logic [W-1:0] din = '0;
  logic         shout = 1'b0;
  logic         odis = 1'b0;
  logic         in_rdy, out_rdy, oe;
  logic [W-1:0] dout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ripple_fifo u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mreset_i    (mreset),
    .shift_in_i  (shin),
    .data_i      (din),
    .shift_out_i (shout),
    .out_dis_i   (odis),
    .in_ready_o  (in_rdy),
    .out_ready_o (out_rdy),
    .data_o      (dout),
    .data_oe_o   (oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wait_ticks(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic pulse_in(input logic [W-1:0] w);
    din  = w;
    shin = 1'b1;
    tick();
    shin = 1'b0;
  endtask

  task automatic load_word(input logic [W-1:0] w);
    for (int k = 0; k < 100 && !in_rdy; k++) tick();
    pulse_in(w);
  endtask

  task automatic unload_word(input logic [W-1:0] exp, input string req);
    for (int k = 0; k < 100 && !out_rdy; k++) tick();
    chk(dout == exp, req, dout, exp);
    shout = 1'b1;
    tick();
    shout = 1'b0;
    tick();
    chk(out_rdy == 1'b0, "R6", out_rdy, 0);
  endtask

  initial begin
    int n;
    logic [W-1:0] held;
    #10;
    rst_n = 1'b1;
    tick();
    // reset state
    chk(in_rdy == 1'b1, "R1", in_rdy, 1);
    chk(out_rdy == 1'b0, "R1", out_rdy, 0);
    chk(oe == 1'b1, "R10", oe, 1);

    // single word: input-ready blip and fall-through latency
    pulse_in(4'hA);
    chk(in_rdy == 1'b0, "R3", in_rdy, 0);
    n = 0;
    tick();
    n++;
    chk(in_rdy == 1'b1, "R3", in_rdy, 1);
    while (!out_rdy && n < 100) begin tick(); n++; end
    chk(n == D - 1, "R4", n, D - 1);
    chk(dout == 4'hA, "R4", dout, 4'hA);
    unload_word(4'hA, "R5");
    wait_ticks(3);
    chk(out_rdy == 1'b0, "R6", out_rdy, 0);

    // unload strobes on an empty FIFO and on an in-flight word are ignored
    shout = 1'b1; tick(); shout = 1'b0; tick();
    pulse_in(4'h3);
    wait_ticks(4);
    shout = 1'b1; tick(); shout = 1'b0; tick();
    wait_ticks(20);
    chk(out_rdy == 1'b1 && dout == 4'h3, "R7", dout, 4'h3);
    unload_word(4'h3, "R7");

    // fill to capacity, then drain in order
    for (int i = 0; i < D; i++) load_word(W'((i * 7 + 3) % 16));
    wait_ticks(40);
    chk(in_rdy == 1'b0, "R11", in_rdy, 0);
    chk(out_rdy == 1'b1, "R11", out_rdy, 1);
    pulse_in(4'hF);
    wait_ticks(3);
    for (int i = 0; i < D; i++) begin
      unload_word(W'((i * 7 + 3) % 16), "R5");
      if (i == 0) begin
        tick();
        chk(out_rdy == 1'b1, "R6", out_rdy, 1);
      end
    end
    wait_ticks(40);
    chk(out_rdy == 1'b0, "R11", out_rdy, 0);
    chk(in_rdy == 1'b1, "R11", in_rdy, 1);

    // held shift-in captures one word only
    din = 4'h6;
    shin = 1'b1;
    wait_ticks(30);
    din = 4'h9;
    wait_ticks(10);
    shin = 1'b0;
    wait_ticks(5);
    chk(out_rdy == 1'b1 && dout == 4'h6, "R2", dout, 4'h6);
    unload_word(4'h6, "R2");
    wait_ticks(40);
    chk(out_rdy == 1'b0, "R2", out_rdy, 0);

    // output disable blocks unloads; re-enable with shift-out low discards
    load_word(4'h1);
    load_word(4'h2);
    wait_ticks(30);
    odis = 1'b1;
    #1;
    chk(oe == 1'b0, "R10", oe, 0);
    tick();
    shout = 1'b1; tick(); shout = 1'b0; tick();
    wait_ticks(3);
    chk(out_rdy == 1'b1 && dout == 4'h1, "R7", dout, 4'h1);
    odis = 1'b0;
    tick();
    chk(out_rdy == 1'b0, "R8", out_rdy, 0);
    tick();
    chk(out_rdy == 1'b1 && dout == 4'h2, "R8", dout, 4'h2);
    chk(oe == 1'b1, "R10", oe, 1);

    // master reset: flags cleared, data kept, strobes ignored
    load_word(4'h5);
    wait_ticks(5);
    held = dout;
    mreset = 1'b1;
    tick();
    chk(in_rdy == 1'b1 && out_rdy == 1'b0, "R1", out_rdy, 0);
    chk(dout == held, "R9", dout, held);
    shin = 1'b1; din = 4'hC; shout = 1'b1;
    tick();
    shin = 1'b0; shout = 1'b0;
    tick();
    mreset = 1'b0;
    wait_ticks(40);
    chk(out_rdy == 1'b0 && in_rdy == 1'b1, "R12", out_rdy, 0);
    chk(dout == held, "R9", dout, held);
    pulse_in(4'hD);
    wait_ticks(20);
    chk(out_rdy == 1'b1 && dout == 4'hD, "R9", dout, 4'hD);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule